// File: doc/BRIEF.md
# Split-Carry Packed Adder

This block adds two 32-bit words through a ripple carry chain that a runtime mask can cut at any bit position. A set mask bit marks the lowest bit of a new element: no carry enters that bit from the bit below it. Fields of any width can therefore be summed side by side in one word. Examples are two 5/6/5 colour pixels, thirty-two 1-bit fields, or one field of 32 bits.

Each operation selects either a scalar add or a packed add. A scalar add ignores the mask and produces the ordinary 32-bit sum. A packed add honours the mask. The mask is held in a register with a write strobe and can always be read back. Results are registered and appear one cycle after the input strobe.

Top module: `split_carry_adder`

## Requirements
- R1: When `op_packed` is 0 (scalar add), `sum_out` is `(opa + opb) mod 2^32` whatever the mask register holds.
- R2: When `op_packed` is 1 (packed add), each set mask bit i (i > 0) stops the carry out of bit i-1 from entering bit i. Each element runs from one set bit up to the bit below the next set bit, or up to bit 31. Its sum wraps modulo 2^width, and the carry out of its top bit is discarded.
- R3: Mask bit 0 has no effect. A packed add with an all-zero mask gives the same result as a scalar add.
- R4: With mask `32'h0821_0820` (bits 5, 11, 16, 21 and 27 set), a packed add sums the fields 4..0, 10..5, 15..11, 20..16, 26..21 and 31..27 independently, which is two 5/6/5 pixels.
- R5: With mask `32'hFFFF_FFFF`, a packed add gives `opa ^ opb`, which is thirty-two 1-bit elements.
- R6: The mask register resets to 0. A cycle with `mask_we` high loads `mask_wdata`, which is read back unchanged on `mask_rdata` from the next cycle. A cycle with `mask_we` low leaves `mask_rdata` unchanged.
- R7: An operation issued in the same cycle as a mask write uses the old mask. An operation issued in the following cycle uses the new mask.
- R8: `out_valid` is high in the cycle after each cycle in which `in_valid` is high, and low otherwise. `sum_out` carries that operation's result and holds its value when no operation is issued.
- R9: After reset, `out_valid` is 0, `sum_out` is 0 and `mask_rdata` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Issue an add this cycle |
| op_packed | input | 1 | 1 = packed add (mask honoured), 0 = scalar add |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand |
| mask_we | input | 1 | Load the partition mask |
| mask_wdata | input | 32 | New partition mask |
| mask_rdata | output | 32 | Current partition mask |
| out_valid | output | 1 | Result valid, one cycle per issued add |
| sum_out | output | 32 | Registered sum |

## Verification
Every add result is due exactly one rising edge after its strobe. The bench drives on the falling edge and checks `out_valid` and `sum_out` at the next falling edge. One falling edge later it checks that `out_valid` has dropped and `sum_out` has held. A mask write also takes effect after one edge. The bench issues an add in the write cycle and checks that add against the old mask, then issues the next add and checks it against the new mask. Packed results are compared with a bench function that extracts and adds each mask-defined field separately.

// File: rtl/split_add_pkg.sv
// Package: shared width and operation encoding for the split-carry adder.
// Assumes a single data width shared by operands, result and mask.
package split_add_pkg;
    localparam int unsigned DATA_W = 32;

    typedef enum logic {
        OP_SCALAR = 1'b0,
        OP_PACKED = 1'b1
    } add_op_e;
endpackage

// File: rtl/sca_mask_reg.sv
// Module: sca_mask_reg
// Holds the partition mask. Loads on a write strobe and resets to all zero.
// Assumes a synchronous active-low reset.
module sca_mask_reg #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] mask_q
);
    // Mask storage: clear on reset, load on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q <= '0;
        end else if (we) begin
            mask_q <= wdata;
        end
    end
endmodule

// File: rtl/sca_carry_chain.sv
// Module: sca_carry_chain
// Ripple adder whose carry into bit i is cut when seg_en is high and brk[i] is set.
// Purely combinational. Carry into bit 0 is always zero and the final carry out is dropped.
module sca_carry_chain #(
    parameter int unsigned W = 32
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic [W-1:0] brk,
    input  logic         seg_en,
    output logic [W-1:0] sum
);
    logic [W-1:0] cin_raw;
    logic [W-1:0] cin_eff;

    for (genvar i = 0; i < W; i++) begin : g_bit
        if (i == 0) begin : g_lsb
            assign cin_raw[i] = 1'b0;
        end else begin : g_upper
            // Carry out of the bit below (majority of its inputs).
            assign cin_raw[i] = (a[i-1] & b[i-1]) | (a[i-1] & cin_eff[i-1])
                              | (b[i-1] & cin_eff[i-1]);
        end
        // Break the chain at an element boundary during a packed add.
        assign cin_eff[i] = cin_raw[i] & ~(seg_en & brk[i]);
        assign sum[i]     = a[i] ^ b[i] ^ cin_eff[i];
    end
endmodule

// File: rtl/split_carry_adder.sv
// Module: split_carry_adder (top)
// Scalar or mask-partitioned packed 32-bit add with a registered result.
// Assumes a synchronous active-low reset. An add issued in a mask-write cycle sees the old mask.
module split_carry_adder
    import split_add_pkg::*;
#(
    parameter int unsigned W = DATA_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    input  logic         op_packed,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    input  logic         mask_we,
    input  logic [W-1:0] mask_wdata,
    output logic [W-1:0] mask_rdata,
    output logic         out_valid,
    output logic [W-1:0] sum_out
);
    add_op_e      op_sel;
    logic [W-1:0] mask_q;
    logic [W-1:0] sum_comb;

    // Decode the operation select into the package encoding.
    always_comb begin
        op_sel = add_op_e'(op_packed);
    end

    sca_mask_reg #(.W(W)) u_mask (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (mask_we),
        .wdata  (mask_wdata),
        .mask_q (mask_q)
    );

    sca_carry_chain #(.W(W)) u_chain (
        .a      (opa),
        .b      (opb),
        .brk    (mask_q),
        .seg_en (op_sel == OP_PACKED),
        .sum    (sum_comb)
    );

    // Result register: capture the sum on a strobe and hold it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            sum_out   <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                sum_out <= sum_comb;
            end
        end
    end

    assign mask_rdata = mask_q;
endmodule

// File: rtl/sca_checker.sv
// Module: sca_checker
// Clocked properties on the split-carry adder ports. Bound into every instance of the top.
module sca_checker #(
    parameter int unsigned W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic         op_packed,
    input logic [W-1:0] opa,
    input logic [W-1:0] opb,
    input logic         mask_we,
    input logic [W-1:0] mask_wdata,
    input logic [W-1:0] mask_rdata,
    input logic         out_valid,
    input logic [W-1:0] sum_out
);
    p_valid_follows_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_valid_single_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    p_sum_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(sum_out));

    p_scalar_sum_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !op_packed) |=> (sum_out == $past(opa) + $past(opb)));

    p_zero_mask_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_packed && (mask_rdata == '0)) |=> (sum_out == $past(opa) + $past(opb)));

    p_ones_mask_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_packed && (mask_rdata == '1)) |=> (sum_out == ($past(opa) ^ $past(opb))));

    p_mask_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mask_we |=> (mask_rdata == $past(mask_wdata)));

    p_mask_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_we |=> $stable(mask_rdata));
endmodule

bind split_carry_adder sca_checker #(.W(W)) u_sca_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (in_valid),
    .op_packed  (op_packed),
    .opa        (opa),
    .opb        (opb),
    .mask_we    (mask_we),
    .mask_wdata (mask_wdata),
    .mask_rdata (mask_rdata),
    .out_valid  (out_valid),
    .sum_out    (sum_out)
);

// File: tb/split_carry_adder_tb_top.sv
// Bench for split_carry_adder: directed corner cases plus seeded random vectors.
module split_carry_adder_tb_top;
    localparam int unsigned CLK_PERIOD = 10;
    localparam logic [31:0] PIX565     = 32'h0821_0820;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        op_packed = 1'b0;
    logic [31:0] opa = '0;
    logic [31:0] opb = '0;
    logic        mask_we = 1'b0;
    logic [31:0] mask_wdata = '0;
    logic [31:0] mask_rdata;
    logic        out_valid;
    logic [31:0] sum_out;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    logic [31:0] cur_mask = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    split_carry_adder dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .in_valid   (in_valid),
        .op_packed  (op_packed),
        .opa        (opa),
        .opb        (opb),
        .mask_we    (mask_we),
        .mask_wdata (mask_wdata),
        .mask_rdata (mask_rdata),
        .out_valid  (out_valid),
        .sum_out    (sum_out)
    );

    // Reference: add every mask-defined field on its own, wrapping at its width.
    function automatic logic [31:0] ref_packed(input logic [31:0] a, input logic [31:0] b,
                                               input logic [31:0] m);
        logic [31:0] r = '0;
        int          lo = 0;
        for (int i = 1; i <= 32; i++) begin
            if (i == 32 || m[i]) begin
                logic [63:0] fmask = (64'd1 << (i - lo)) - 64'd1;
                logic [63:0] fsum  = ((64'(a) >> lo) & fmask) + ((64'(b) >> lo) & fmask);
                r  = r | 32'((fsum & fmask) << lo);
                lo = i;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Write the mask and confirm the readback one cycle later.
    task automatic write_mask(input logic [31:0] m);
        @(negedge clk);
        mask_we    = 1'b1;
        mask_wdata = m;
        @(negedge clk);
        mask_we  = 1'b0;
        cur_mask = m;
        check("R6 readback", mask_rdata, m);
    endtask

    // Issue one add and check its result one edge later.
    task automatic do_add(input string req, input logic pk, input logic [31:0] a,
                          input logic [31:0] b, input logic [31:0] exp);
        @(negedge clk);
        in_valid  = 1'b1;
        op_packed = pk;
        opa       = a;
        opb       = b;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {31'd0, out_valid}, 32'd1);
        check(req, sum_out, exp);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] a;
        logic [31:0] b;
        logic [31:0] m;
        void'($urandom(32'd20240613));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R9: reset state.
        check("R9 out_valid", {31'd0, out_valid}, 32'd0);
        check("R9 sum_out", sum_out, 32'd0);
        check("R9 mask", mask_rdata, 32'd0);
        // R3: zero mask packed equals scalar, including a full carry ripple.
        do_add("R3 zero mask", 1'b1, 32'hFFFF_FFFF, 32'h0000_0001, 32'h0000_0000);
        // R8: valid drops and the sum holds.
        @(negedge clk);
        check("R8 valid low", {31'd0, out_valid}, 32'd0);
        check("R8 hold", sum_out, 32'h0000_0000);
        // R4: two 5/6/5 pixels, every field overflows.
        write_mask(PIX565);
        do_add("R4 pixel", 1'b1, 32'hFFFF_FFFF, 32'h0821_0821, 32'h0000_0000);
        do_add("R4 pixel mix", 1'b1, 32'h1234_5678, 32'h9ABC_DEF0,
               ref_packed(32'h1234_5678, 32'h9ABC_DEF0, PIX565));
        // R1: scalar ignores the mask.
        do_add("R1 scalar", 1'b0, 32'hFFFF_FFFF, 32'h0821_0821, 32'h0821_0820);
        // R7: same-cycle write uses the old mask; the next add sees the new one.
        @(negedge clk);
        mask_we = 1'b1; mask_wdata = 32'hFFFF_FFFF;
        in_valid = 1'b1; op_packed = 1'b1; opa = 32'h0000_FFFF; opb = 32'h0000_0001;
        @(negedge clk);
        mask_we = 1'b0; in_valid = 1'b0;
        cur_mask = 32'hFFFF_FFFF;
        check("R7 old mask", sum_out, ref_packed(32'h0000_FFFF, 32'h0000_0001, PIX565));
        check("R7 readback", mask_rdata, 32'hFFFF_FFFF);
        // R5: all-ones mask gives bitwise XOR.
        do_add("R5 ones", 1'b1, 32'h0000_FFFF, 32'h0000_0001, 32'h0000_FFFE);
        // R3: mask bit 0 alone has no effect.
        write_mask(32'h0000_0001);
        do_add("R3 bit0", 1'b1, 32'h8000_0001, 32'h8000_0001, 32'h0000_0002);
        // R2: random masks and operands against the field reference.
        for (int k = 0; k < 300; k++) begin
            m = $urandom();
            if (k % 3 == 0) m = m & $urandom();
            write_mask(m);
            a = $urandom(); b = $urandom();
            do_add("R2 packed", 1'b1, a, b, ref_packed(a, b, m));
            a = $urandom(); b = $urandom();
            do_add("R1 scalar rnd", 1'b0, a, b, a + b);
        end
        // R8: back-to-back strobes each produce a result.
        @(negedge clk);
        in_valid = 1'b1; op_packed = 1'b0; opa = 32'd5; opb = 32'd6;
        @(negedge clk);
        check("R8 b2b first", sum_out, 32'd11);
        opa = 32'd100; opb = 32'd23;
        @(negedge clk);
        in_valid = 1'b0;
        check("R8 b2b valid", {31'd0, out_valid}, 32'd1);
        check("R8 b2b second", sum_out, 32'd123);
        @(negedge clk);
        check("R8 b2b end", {31'd0, out_valid}, 32'd0);
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule